// File: doc/BRIEF.md
# Branch Target Buffer

This block is a direct-mapped, tagged table consulted with the fetch address every cycle. It returns the address to fetch next. If the looked-up slot is valid, its tag equals the upper address bits, and the slot's 2-bit direction counter is in a taken state, the output is the stored target. In every other case the output is the fetch address plus four.

A second port takes branches after they resolve, together with the actual direction and the actual target. If a resolved branch hits its slot, the counter moves one step toward the outcome and the stored target is replaced. If a resolved taken branch misses, it claims the slot, evicting whatever was there, with a weakly-taken counter. A resolved not-taken branch that misses leaves the table unchanged. Each slot therefore gives both whether to redirect and where to redirect.

Top module: `btb_top`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses and `next_pc` equals `fetch_pc + 4`.
- R2: The slot is picked by `fetch_pc[IDX_W+1:2]`. The tag is every address bit above the index. A lookup hits only when the slot is valid and its tag matches.
- R3: On a lookup miss, `next_pc = fetch_pc + 4` and `hit` is low.
- R4: On a hit where the counter is 2 or 3 (upper bit set), `next_pc` is the stored target and `pred_taken` is high. On a hit where the counter is 0 or 1, `next_pc = fetch_pc + 4`.
- R5: An update that hits a taken branch raises the counter by one, and the counter stays at 3 once it reaches 3. An update that hits a not-taken branch lowers it by one, and it stays at 0 once it reaches 0.
- R6: An update that hits replaces the stored target with `upd_target`.
- R7: A taken update that misses writes the slot as valid, with the new tag, the new target and counter 2. Any previous occupant of the slot is evicted.
- R8: A not-taken update that misses changes nothing. The bench checks this by looking up the same address afterwards.
- R9: A lookup in the same cycle as an update sees the contents as they were before that update. The change is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Lookup address |
| next_pc | output | ADDR_W | Predicted next fetch address (combinational) |
| hit | output | 1 | Lookup matched a valid slot |
| pred_taken | output | 1 | Hit with a counter in a taken state |
| upd_valid | input | 1 | Resolved branch present |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | ADDR_W | Actual target |

## Verification
The bench builds the block with the default 32-bit addresses and 64 slots. At that size a handful of addresses 256 bytes apart all map to the same slot, which exercises eviction and tag mismatch. A reference model in the bench uses associative arrays keyed by slot number. The model is compared with the outputs every cycle, including cycles where a lookup and an update go to the same slot. This brings the counter's saturation at both ends, and visibility of an update only in the following cycle, within a few hundred cycles.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int CTR_W = 2;
  localparam logic [CTR_W-1:0] CTR_WEAK_TAKEN = 2'b10;

  function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] c, input logic taken);
    if (taken) return (c == '1) ? c : c + 1'b1;
    else       return (c == '0) ? c : c - 1'b1;
  endfunction

  function automatic logic ctr_says_taken(input logic [CTR_W-1:0] c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  localparam int TAG_W = ADDR_W - IDX_W - 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              slot_valid,
  input  logic [TAG_W-1:0]  slot_tag,
  input  logic [ADDR_W-1:0] slot_target,
  input  logic [1:0]        slot_ctr,
  output logic              hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] next_pc
);
  import btb_pkg::*;
  logic [ADDR_W-1:0] seq_pc;
  assign seq_pc     = pc + ADDR_W'(4);
  assign hit        = slot_valid && (slot_tag == pc[ADDR_W-1:IDX_W+2]);
  assign pred_taken = hit && ctr_says_taken(slot_ctr);
  assign next_pc    = pred_taken ? slot_target : seq_pc;

  always_comb begin
    if (!hit) assert_miss_seq_R3: assert (next_pc == seq_pc);
  end
endmodule

// File: rtl/btb_top.sv
module btb_top #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] next_pc,
  output logic              hit,
  output logic              pred_taken,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  import btb_pkg::*;
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q    [DEPTH];
  logic [ADDR_W-1:0] target_q [DEPTH];
  logic [CTR_W-1:0]  ctr_q    [DEPTH];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] wr_tag;
  assign rd_idx = fetch_pc[IDX_W+1:2];
  assign wr_idx = upd_pc[IDX_W+1:2];
  assign wr_tag = upd_pc[ADDR_W-1:IDX_W+2];

  btb_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lookup (
    .pc(fetch_pc), .slot_valid(valid_q[rd_idx]), .slot_tag(tag_q[rd_idx]),
    .slot_target(target_q[rd_idx]), .slot_ctr(ctr_q[rd_idx]),
    .hit(hit), .pred_taken(pred_taken), .next_pc(next_pc)
  );

  // named update events
  logic upd_hit, upd_alloc, upd_refresh;
  assign upd_hit     = upd_valid && valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
  assign upd_refresh = upd_hit;
  assign upd_alloc   = upd_valid && !upd_hit && upd_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (upd_alloc) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (upd_alloc) begin
      tag_q[wr_idx]    <= wr_tag;
      target_q[wr_idx] <= upd_target;
      ctr_q[wr_idx]    <= CTR_WEAK_TAKEN;
    end else if (upd_refresh) begin
      target_q[wr_idx] <= upd_target;
      ctr_q[wr_idx]    <= ctr_step(ctr_q[wr_idx], upd_taken);
    end
  end

  assert_alloc_weak_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_alloc |=> (valid_q[$past(wr_idx)] && ctr_q[$past(wr_idx)] == CTR_WEAK_TAKEN));
  assert_refresh_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_refresh |=> target_q[$past(wr_idx)] == $past(upd_target));
  assert_sat_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_refresh && upd_taken && ctr_q[wr_idx] == 2'b11) |=> ctr_q[$past(wr_idx)] == 2'b11);
  assert_sat_bot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_refresh && !upd_taken && ctr_q[wr_idx] == 2'b00) |=> ctr_q[$past(wr_idx)] == 2'b00);
  assert_nt_miss_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_hit && !upd_taken) |=> $stable(valid_q));
  assert_pred_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> hit);
endmodule

// File: tb/sim_btb_top.sv
module sim_btb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] fetch_pc = 0, upd_pc = 0, upd_target = 0;
  logic upd_valid = 0, upd_taken = 0;
  logic [AW-1:0] next_pc;
  logic hit, pred_taken;
  int checks = 0, errors = 0;

  // reference model
  bit     m_v   [int];
  longint m_tag [int];
  longint m_tgt [int];
  int     m_ctr [int];

  btb_top u0 (.clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .hit(hit), .pred_taken(pred_taken), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int slot(logic [AW-1:0] a); return (a / 4) % 64; endfunction
  function automatic longint tagof(logic [AW-1:0] a); return longint'(a) / 256; endfunction

  // R1 R2 R3 R4 R9: compare every cycle against the model (pre-update view)
  always @(negedge clk) if (rst_n) begin
    int s; bit h; bit t; logic [AW-1:0] exp;
    s = slot(fetch_pc);
    h = m_v.exists(s) && m_v[s] && m_tag[s] == tagof(fetch_pc);
    t = h && m_ctr[s] >= 2;
    exp = t ? AW'(m_tgt[s]) : fetch_pc + 4;
    checks++;
    if (hit !== h || pred_taken !== t || next_pc !== exp) begin
      errors++;
      $display("FAIL R2/R3/R4/R9 pc=%h: got hit=%b pt=%b npc=%h exp hit=%b pt=%b npc=%h",
               fetch_pc, hit, pred_taken, next_pc, h, t, exp);
    end
  end

  // model update at the clock edge (R5 R6 R7 R8)
  always @(posedge clk) if (rst_n && upd_valid) begin
    int s; bit h;
    s = slot(upd_pc);
    h = m_v.exists(s) && m_v[s] && m_tag[s] == tagof(upd_pc);
    if (h) begin
      m_tgt[s] = upd_target;
      if (upd_taken) m_ctr[s] = (m_ctr[s] == 3) ? 3 : m_ctr[s] + 1;
      else           m_ctr[s] = (m_ctr[s] == 0) ? 0 : m_ctr[s] - 1;
    end else if (upd_taken) begin
      m_v[s] = 1; m_tag[s] = tagof(upd_pc); m_tgt[s] = upd_target; m_ctr[s] = 2;
    end
  end

  task automatic upd(input logic [AW-1:0] pc, input bit tk, input logic [AW-1:0] tg);
    @(negedge clk);
    upd_valid = 1; upd_pc = pc; upd_taken = tk; upd_target = tg;
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic look(input logic [AW-1:0] pc, input logic [AW-1:0] exp, input string r);
    @(negedge clk); fetch_pc = pc; #1;
    checks++;
    if (next_pc !== exp) begin
      errors++; $display("FAIL %s pc=%h: got %h exp %h", r, pc, next_pc, exp);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++; $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(32'h0000_1000, 32'h0000_1004, "R1");
    look(32'h0000_10FC, 32'h0000_1100, "R1");
    // R8: not-taken miss allocates nothing
    upd(32'h0000_1000, 0, 32'h0000_2000);
    look(32'h0000_1000, 32'h0000_1004, "R8");
    // R7: taken miss allocates weakly taken
    upd(32'h0000_1000, 1, 32'h0000_2000);
    look(32'h0000_1000, 32'h0000_2000, "R7");
    // R2: same slot, different tag misses
    look(32'h0000_1100, 32'h0000_1104, "R2");
    // R5: one not-taken -> 1 -> sequential
    upd(32'h0000_1000, 0, 32'h0000_2000);
    look(32'h0000_1000, 32'h0000_1004, "R5");
    upd(32'h0000_1000, 0, 32'h0000_2000);
    upd(32'h0000_1000, 0, 32'h0000_2000); // saturate at 0
    upd(32'h0000_1000, 1, 32'h0000_2000); // 1
    look(32'h0000_1000, 32'h0000_1004, "R5");
    upd(32'h0000_1000, 1, 32'h0000_3000); // 2, R6 new target
    look(32'h0000_1000, 32'h0000_3000, "R6");
    upd(32'h0000_1000, 1, 32'h0000_3000);
    upd(32'h0000_1000, 1, 32'h0000_3000);
    upd(32'h0000_1000, 1, 32'h0000_3000); // saturate at 3
    upd(32'h0000_1000, 0, 32'h0000_3000); // 2 -> still taken
    look(32'h0000_1000, 32'h0000_3000, "R5");
    // R7: eviction by another tag
    upd(32'h0000_1100, 1, 32'h0000_4000);
    look(32'h0000_1100, 32'h0000_4000, "R7");
    look(32'h0000_1000, 32'h0000_1004, "R7");
    // R9: lookup during update sees old contents (checked by every-cycle compare)
    @(negedge clk);
    fetch_pc = 32'h0000_2200; upd_valid = 1; upd_pc = 32'h0000_2200;
    upd_taken = 1; upd_target = 32'h0000_5550;
    #1; checks++;
    if (next_pc !== 32'h0000_2204) begin
      errors++; $display("FAIL R9 got %h exp %h", next_pc, 32'h0000_2204);
    end
    @(negedge clk); upd_valid = 0; #1; checks++;
    if (next_pc !== 32'h0000_5550) begin
      errors++; $display("FAIL R9 next cycle got %h exp %h", next_pc, 32'h0000_5550);
    end
    // pseudo-random traffic over few slots
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      fetch_pc   = {20'h0, 4'((i*7) % 3), 2'b00, 4'((i*5) % 4), 2'b00};
      upd_valid  = (i % 3) != 0;
      upd_pc     = {20'h0, 4'((i*11) % 3), 2'b00, 4'((i*3) % 4), 2'b00};
      upd_taken  = ((i * 13) % 5) < 3;
      upd_target = 32'h0001_0000 + 32'(i * 4);
    end
    @(negedge clk); upd_valid = 0;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule